// File: doc/BRIEF.md
# Cluster Power-Up Reset Sequencer

This block brings a complete multi-core processor cluster out of its powered-down state before any individual core is started. On a single start request it walks a fixed order of steps: it first marks the cluster's coherency port as inactive, puts every core into power-on reset, and places the cluster-level debug, bus and L2 resets and the per-core debug resets in reset. Trace resets are added for the small-core cluster type. It then pulls the reset-disable lines low according to the cluster type and opens the cluster power gate.

After a programmable settling wait, measured in microseconds and converted to clock cycles by a parameter, the sequencer releases only the cluster-wide resets (debug-SoC, bus, L2). The per-core power-on, debug and trace resets stay asserted for a later per-core bring-up step. Finally it lets the coherency port go active again and pulses a completion flag. A start request that arrives while a sequence is running does not disturb it; it returns a one-cycle error pulse.

All reset outputs are active low. Lines that a step does not drive keep their previous value, so a second run on an already powered cluster is allowed.

Top module: `clus_pwrup_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, the outputs are: `coh_inactive`=0, `core_por_n`=all ones, `dbg_soc_rst_n`=`bus_rst_n`=`l2_rst_n`=1, `core_dbg_rst_n`=`trace_rst_n`=all ones, `l1_rst_inhibit`=all ones, `l2_rst_inhibit`=1, `clus_pwr_gate`=1, `done_pulse`=0, `err_pulse`=0.
- R2: A `start_req` seen high at a clock edge (edge E0) while idle is accepted, and `coh_inactive` goes to 1 after edge E1.
- R3: After edge E2 every bit of `core_por_n` is 0.
- R4: After edge E3, `dbg_soc_rst_n`, `bus_rst_n`, `l2_rst_n` and all bits of `core_dbg_rst_n` are 0. All bits of `trace_rst_n` go to 0 only when the cluster type was small (`clus_big`=0 at E0); for the big type (`clus_big`=1) they keep their previous value.
- R5: After edge E4, `l2_rst_inhibit` is 0. For the small type all bits of `l1_rst_inhibit` are also 0; for the big type they keep their previous value.
- R6: After edge E5, `clus_pwr_gate` is 0 (1 means gated off, 0 means powered).
- R7: With W = CYC_PER_US*WAIT_US, `dbg_soc_rst_n`, `bus_rst_n` and `l2_rst_n` stay 0 through edge E5+W and go to 1 after edge E6+W, at least W cycles after the gate opened. `core_por_n`, `core_dbg_rst_n` and `trace_rst_n` are not released.
- R8: After edge E7+W, `coh_inactive` is 0 and `done_pulse` is 1 for exactly one cycle.
- R9: A `start_req` seen at an edge while a sequence runs is ignored: the running sequence keeps its timing and its latched cluster type, and `err_pulse` is 1 for the cycle after that edge.
- R10: A sequence may be repeated after completion. Lines that a step leaves alone hold their value from the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request to run the power-up sequence |
| clus_big | input | 1 | Cluster type: 1 = big cores, 0 = small cores |
| coh_inactive | output | 1 | Coherency port inactive indication |
| core_por_n | output | NUM_CORES | Per-core power-on reset, active low |
| dbg_soc_rst_n | output | 1 | Cluster debug-SoC reset, active low |
| core_dbg_rst_n | output | NUM_CORES | Per-core debug reset, active low |
| bus_rst_n | output | 1 | Cluster bus interface reset, active low |
| l2_rst_n | output | 1 | Cluster L2 reset, active low |
| trace_rst_n | output | NUM_CORES | Per-core trace reset, active low |
| l1_rst_inhibit | output | NUM_CORES | Per-core L1 reset-disable line |
| l2_rst_inhibit | output | 1 | Cluster L2 reset-disable line |
| clus_pwr_gate | output | 1 | Cluster power gate, 1 = off |
| done_pulse | output | 1 | One-cycle completion pulse |
| err_pulse | output | 1 | One-cycle pulse for a start refused while busy |

## Verification
Counting from the edge E0 that accepts a start, each output step lands one edge later than the previous one: coherency after E1, core resets after E2, cluster resets after E3, reset-disable lines after E4, and the power gate after E5. The release is due after E6+W and completion after E7+W, and an `err_pulse` appears after the edge that saw a refused start. The bench steps one edge at a time and samples on the falling edge that follows each due edge. It also checks the cycle just before the release, so that a release one cycle early or late is caught.

// File: rtl/clus_pwrup_pkg.sv
package clus_pwrup_pkg;

  // Sequence steps; each active step lasts one cycle except ST_WAIT.
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_COH_ON,
    ST_POR,
    ST_CRST,
    ST_RDIS,
    ST_GATE,
    ST_WAIT,
    ST_REL,
    ST_COH_OFF
  } step_e;

  localparam logic CT_SMALL = 1'b0;
  localparam logic CT_BIG   = 1'b1;

endpackage

// File: rtl/clus_pwrup_timer.sv
module clus_pwrup_timer #(
  parameter int unsigned LIMIT = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);

  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    if (load) cnt_d = CW'(LIMIT - 1);
    else      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/clus_pwrup_fsm.sv
module clus_pwrup_fsm
  import clus_pwrup_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_req,
  input  logic  wait_done,
  output step_e step,
  output logic  accept,
  output logic  reject,
  output logic  tmr_load
);

  step_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_req) state_d = ST_COH_ON;
      ST_COH_ON:  state_d = ST_POR;
      ST_POR:     state_d = ST_CRST;
      ST_CRST:    state_d = ST_RDIS;
      ST_RDIS:    state_d = ST_GATE;
      ST_GATE:    state_d = ST_WAIT;
      ST_WAIT:    if (wait_done) state_d = ST_REL;
      ST_REL:     state_d = ST_COH_OFF;
      ST_COH_OFF: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign step     = state_q;
  assign accept   = start_req & (state_q == ST_IDLE);
  assign reject   = start_req & (state_q != ST_IDLE);
  assign tmr_load = (state_q == ST_GATE);

endmodule

// File: rtl/clus_pwrup_ctrl.sv
module clus_pwrup_ctrl
  import clus_pwrup_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  step_e                step,
  input  logic                 accept,
  input  logic                 reject,
  input  logic                 clus_big,
  output logic                 coh_inactive,
  output logic [NUM_CORES-1:0] core_por_n,
  output logic                 dbg_soc_rst_n,
  output logic [NUM_CORES-1:0] core_dbg_rst_n,
  output logic                 bus_rst_n,
  output logic                 l2_rst_n,
  output logic [NUM_CORES-1:0] trace_rst_n,
  output logic [NUM_CORES-1:0] l1_rst_inhibit,
  output logic                 l2_rst_inhibit,
  output logic                 clus_pwr_gate,
  output logic                 done_pulse,
  output logic                 err_pulse
);

  logic type_q;
  logic coh_q, coh_d, coh_en;
  logic crst_q, crst_d, crst_en;
  logic l2dis_q, l2dis_en;
  logic gate_q, gate_en;
  logic done_q, done_d;
  logic err_q, err_d;
  logic por_en, dbg_en, trc_en, l1_en;

  always_comb begin
    coh_en   = (step == ST_COH_ON) | (step == ST_COH_OFF);
    coh_d    = (step == ST_COH_ON);
    crst_en  = (step == ST_CRST) | (step == ST_REL);
    crst_d   = (step == ST_REL);
    l2dis_en = (step == ST_RDIS);
    gate_en  = (step == ST_GATE);
    done_d   = (step == ST_COH_OFF);
    err_d    = reject;
    por_en   = (step == ST_POR);
    dbg_en   = (step == ST_CRST);
    trc_en   = (step == ST_CRST) & (type_q == CT_SMALL);
    l1_en    = (step == ST_RDIS) & (type_q == CT_SMALL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q  <= CT_SMALL;
      coh_q   <= 1'b0;
      crst_q  <= 1'b1;
      l2dis_q <= 1'b1;
      gate_q  <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (accept)   type_q  <= clus_big;
      if (coh_en)   coh_q   <= coh_d;
      if (crst_en)  crst_q  <= crst_d;
      if (l2dis_en) l2dis_q <= 1'b0;
      if (gate_en)  gate_q  <= 1'b0;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_lane
    logic por_q, dbg_q, trc_q, l1_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        por_q <= 1'b1;
        dbg_q <= 1'b1;
        trc_q <= 1'b1;
        l1_q  <= 1'b1;
      end else begin
        if (por_en) por_q <= 1'b0;
        if (dbg_en) dbg_q <= 1'b0;
        if (trc_en) trc_q <= 1'b0;
        if (l1_en)  l1_q  <= 1'b0;
      end
    end
    assign core_por_n[i]     = por_q;
    assign core_dbg_rst_n[i] = dbg_q;
    assign trace_rst_n[i]    = trc_q;
    assign l1_rst_inhibit[i] = l1_q;
  end

  assign coh_inactive   = coh_q;
  assign dbg_soc_rst_n  = crst_q;
  assign bus_rst_n      = crst_q;
  assign l2_rst_n       = crst_q;
  assign l2_rst_inhibit = l2dis_q;
  assign clus_pwr_gate  = gate_q;
  assign done_pulse     = done_q;
  assign err_pulse      = err_q;

endmodule

// File: rtl/clus_pwrup_seq.sv
module clus_pwrup_seq
  import clus_pwrup_pkg::*;
#(
  parameter int unsigned NUM_CORES  = 4,
  parameter int unsigned CYC_PER_US = 10,
  parameter int unsigned WAIT_US    = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_req,
  input  logic                 clus_big,
  output logic                 coh_inactive,
  output logic [NUM_CORES-1:0] core_por_n,
  output logic                 dbg_soc_rst_n,
  output logic [NUM_CORES-1:0] core_dbg_rst_n,
  output logic                 bus_rst_n,
  output logic                 l2_rst_n,
  output logic [NUM_CORES-1:0] trace_rst_n,
  output logic [NUM_CORES-1:0] l1_rst_inhibit,
  output logic                 l2_rst_inhibit,
  output logic                 clus_pwr_gate,
  output logic                 done_pulse,
  output logic                 err_pulse
);

  localparam int unsigned WAIT_CYC = CYC_PER_US * WAIT_US;

  step_e step;
  logic  accept, reject, tmr_load, wait_done;

  clus_pwrup_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .wait_done (wait_done),
    .step      (step),
    .accept    (accept),
    .reject    (reject),
    .tmr_load  (tmr_load)
  );

  clus_pwrup_timer #(.LIMIT(WAIT_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .expired (wait_done)
  );

  clus_pwrup_ctrl #(.NUM_CORES(NUM_CORES)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .step           (step),
    .accept         (accept),
    .reject         (reject),
    .clus_big       (clus_big),
    .coh_inactive   (coh_inactive),
    .core_por_n     (core_por_n),
    .dbg_soc_rst_n  (dbg_soc_rst_n),
    .core_dbg_rst_n (core_dbg_rst_n),
    .bus_rst_n      (bus_rst_n),
    .l2_rst_n       (l2_rst_n),
    .trace_rst_n    (trace_rst_n),
    .l1_rst_inhibit (l1_rst_inhibit),
    .l2_rst_inhibit (l2_rst_inhibit),
    .clus_pwr_gate  (clus_pwr_gate),
    .done_pulse     (done_pulse),
    .err_pulse      (err_pulse)
  );

endmodule

// File: rtl/clus_pwrup_chk.sv
module clus_pwrup_chk #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned WAIT_CYC  = 200
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 coh_inactive,
  input logic [NUM_CORES-1:0] core_por_n,
  input logic                 dbg_soc_rst_n,
  input logic                 bus_rst_n,
  input logic                 l2_rst_n,
  input logic                 l2_rst_inhibit,
  input logic                 clus_pwr_gate,
  input logic                 done_pulse
);

  localparam int unsigned CW = $clog2(WAIT_CYC + 1);

  logic [CW-1:0] l2_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          l2_low_cnt <= '0;
    else if (l2_rst_n)                   l2_low_cnt <= '0;
    else if (l2_low_cnt < CW'(WAIT_CYC)) l2_low_cnt <= l2_low_cnt + CW'(1);
  end

  assert_gate_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clus_pwr_gate) |-> coh_inactive && (core_por_n == '0) && !l2_rst_n && !l2_rst_inhibit);

  assert_settle_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l2_rst_n) |-> (l2_low_cnt >= CW'(WAIT_CYC)));

  assert_core_por_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_por_n & ~$past(core_por_n)) == '0);

  assert_coh_after_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(coh_inactive) |-> l2_rst_n && bus_rst_n && dbg_soc_rst_n && !clus_pwr_gate);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  assert_done_with_coh_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> !coh_inactive);

endmodule

bind clus_pwrup_seq clus_pwrup_chk #(
  .NUM_CORES (NUM_CORES),
  .WAIT_CYC  (CYC_PER_US * WAIT_US)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .coh_inactive   (coh_inactive),
  .core_por_n     (core_por_n),
  .dbg_soc_rst_n  (dbg_soc_rst_n),
  .bus_rst_n      (bus_rst_n),
  .l2_rst_n       (l2_rst_n),
  .l2_rst_inhibit (l2_rst_inhibit),
  .clus_pwr_gate  (clus_pwr_gate),
  .done_pulse     (done_pulse)
);

// File: tb/sim_clus_pwrup_seq.sv
`timescale 1ns/1ps
module sim_clus_pwrup_seq;

  localparam int NC  = 4;
  localparam int CPU = 2;
  localparam int WUS = 20;
  localparam int W   = CPU * WUS;

  // Vector: [9] big type, [8] poke a refused start mid-wait,
  //         [7:4] expected trace_rst_n, [3:0] expected l1_rst_inhibit
  localparam logic [9:0] VEC [4] = '{
    {1'b1, 1'b0, 4'hF, 4'hF},
    {1'b1, 1'b1, 4'hF, 4'hF},
    {1'b0, 1'b1, 4'h0, 4'h0},
    {1'b1, 1'b0, 4'h0, 4'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0;
  logic clus_big = 1'b0;
  logic coh_inactive, dbg_soc_rst_n, bus_rst_n, l2_rst_n;
  logic l2_rst_inhibit, clus_pwr_gate, done_pulse, err_pulse;
  logic [NC-1:0] core_por_n, core_dbg_rst_n, trace_rst_n, l1_rst_inhibit;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  clus_pwrup_seq #(.NUM_CORES(NC), .CYC_PER_US(CPU), .WAIT_US(WUS)) u0 (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .clus_big(clus_big),
    .coh_inactive(coh_inactive), .core_por_n(core_por_n),
    .dbg_soc_rst_n(dbg_soc_rst_n), .core_dbg_rst_n(core_dbg_rst_n),
    .bus_rst_n(bus_rst_n), .l2_rst_n(l2_rst_n), .trace_rst_n(trace_rst_n),
    .l1_rst_inhibit(l1_rst_inhibit), .l2_rst_inhibit(l2_rst_inhibit),
    .clus_pwr_gate(clus_pwr_gate), .done_pulse(done_pulse), .err_pulse(err_pulse)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_reset_state(input string tag);
    chk("R1", {tag, " coh_inactive"}, coh_inactive, 0);
    chk("R1", {tag, " core_por_n"}, core_por_n, 4'hF);
    chk("R1", {tag, " cluster resets"}, {dbg_soc_rst_n, bus_rst_n, l2_rst_n}, 3'b111);
    chk("R1", {tag, " core_dbg/trace"}, {core_dbg_rst_n, trace_rst_n}, 8'hFF);
    chk("R1", {tag, " inhibits"}, {l1_rst_inhibit, l2_rst_inhibit}, 5'h1F);
    chk("R1", {tag, " gate/done/err"}, {clus_pwr_gate, done_pulse, err_pulse}, 3'b100);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_reset_state("in reset");
    rst_n = 1'b1;
    step();
    chk_reset_state("after release");

    foreach (VEC[k]) begin
      logic big, poke;
      logic [3:0] etr, el1;
      {big, poke, etr, el1} = VEC[k];
      start_req = 1'b1;
      clus_big  = big;
      step();                                   // E0
      start_req = 1'b0;
      chk("R2", "coh not yet at E0", coh_inactive, 0);
      step();                                   // E1
      chk("R2", "coh_inactive set", coh_inactive, 1);
      step();                                   // E2
      chk("R3", "core_por_n asserted", core_por_n, 4'h0);
      step();                                   // E3
      chk("R4", "cluster resets asserted", {dbg_soc_rst_n, bus_rst_n, l2_rst_n}, 3'b000);
      chk("R4", "core debug resets", core_dbg_rst_n, 4'h0);
      chk("R4", "trace resets by type", trace_rst_n, etr);
      step();                                   // E4
      chk("R5", "l2 inhibit low", l2_rst_inhibit, 0);
      chk("R5", "l1 inhibit by type", l1_rst_inhibit, el1);
      step();                                   // E5
      chk("R6", "power gate open", clus_pwr_gate, 0);
      for (int i = 0; i < W; i++) begin
        if (poke && i == 3) begin
          start_req = 1'b1;
          clus_big  = ~big;
        end
        step();
        if (poke && i == 3) begin
          start_req = 1'b0;
          chk("R9", "err pulse on busy start", err_pulse, 1);
        end
      end                                       // now after E5+W
      chk("R7", "no early release", l2_rst_n, 0);
      chk("R9", "err pulse cleared", err_pulse, 0);
      step();                                   // E6+W
      chk("R7", "cluster resets released", {dbg_soc_rst_n, bus_rst_n, l2_rst_n}, 3'b111);
      chk("R7", "core por held", core_por_n, 4'h0);
      chk("R7", "core debug held", core_dbg_rst_n, 4'h0);
      chk("R10", "trace unchanged", trace_rst_n, etr);
      chk("R9", "l1 kept latched type", l1_rst_inhibit, el1);
      chk("R8", "no done before end", done_pulse, 0);
      step();                                   // E7+W
      chk("R8", "coh_inactive cleared", coh_inactive, 0);
      chk("R8", "done pulse", done_pulse, 1);
      step();
      chk("R8", "done single cycle", done_pulse, 0);
      chk("R10", "gate stays open", clus_pwr_gate, 0);
      step();
    end

    // Reset in the middle of a sequence
    start_req = 1'b1;
    clus_big  = 1'b0;
    step();
    start_req = 1'b0;
    repeat (3) step();
    rst_n = 1'b0;
    #1;
    chk_reset_state("mid-sequence reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1", "idle after reset, coh", coh_inactive, 0);
    chk("R1", "idle after reset, gate", clus_pwr_gate, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule